// File: doc/BRIEF.md
# Nametable Page Extension Snooper

This block sits beside a tile-based video controller. It watches the controller's video-memory fetch bus and supplies one extra address bit for nametable accesses. With that bit the background can span twice as many horizontal screen pages as the controller can address by itself. The CPU never writes the bit. The block derives it from the order of the fetches alone.

On every pixel clock the block samples the fetch address and the read strobe. A single idle cycle between two fetch cycles marks the end of a scanline. That gap clears the tracking state. Within a line, a nametable fetch from the left page that comes after a fetch from the right page means the scroll has wrapped. From that fetch until the next gap the extra bit is 1, and it is driven only while a nametable fetch is on the bus.

The first two tiles of a line are fetched near the end of the previous line, so they use that line's state. Mid-frame scroll splits are therefore outside the block's scope. The pre-render line's dummy fetches include a gap, which brings the tracking state into a valid condition before the first visible line.

Top module: `nt_page_ext`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ext_o` is 0 after that edge, and all tracking state is cleared, so the first nametable fetch after reset gives 0.
- R2: A cycle that is not a nametable fetch makes `ext_o` 0 one cycle later. A nametable fetch has `fetch_rd` high and `fetch_addr[13:12]` equal to 2'b10, which covers addresses 0x2000 to 0x2FFF. Every other cycle is not a nametable fetch, including addresses 0x3000 and up.
- R3: A gap is one cycle with `fetch_rd` low, with `fetch_rd` high in the cycle before and the cycle after. The fetch cycle that follows a gap is evaluated with cleared state.
- R4: A left-page nametable fetch (`fetch_addr[10]`=0) that comes after any right-page nametable fetch (`fetch_addr[10]`=1) since the last gap gives `ext_o`=1. A right-page fetch gives 0 unless the bit is already set.
- R5: Once the bit is set, every later nametable fetch on either page gives 1 until a gap.
- R6: `ext_o` is registered. It reflects the fetch sampled at the previous rising edge and stays constant for the whole cycle.
- R7: On a line with no right-page nametable fetch, `ext_o` stays 0.
- R8: An idle stretch of two or more cycles is not a gap. The tracking state is held across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_addr | input | 14 | Video-memory fetch address |
| fetch_rd | input | 1 | Fetch read strobe, high during a fetch cycle |
| ext_o | output | 1 | Extra nametable address bit, registered |

## Verification
The hardest state to reach from the ports is the boundary between lines. There, the clearing must act on the very first fetch after a one-cycle idle slot, while a two-cycle idle slot must leave the state intact. The stimulus table builds a line that wraps and a line that does not, separated by a single idle slot. It then inserts a double idle slot after a right-page fetch, followed by a left fetch that must still read 1. Finally, a gap followed directly by a right-page fetch shows that the cleared state, not the held one, is used.

// File: rtl/snp_pkg.sv
// Package: shared types and constants for the nametable page snooper.
// Assumes a 14-bit video address space with nametables in 0x2000-0x2FFF.
package snp_pkg;
    localparam int ADDR_W_DEF     = 14;
    localparam int PAGE_BIT_DEF   = 10;
    localparam int REGION_MSB_DEF = 13;
    localparam int REGION_LSB_DEF = 12;
    localparam int REGION_VAL_DEF = 2;

    // Classification of the fetch on the bus in the current cycle.
    typedef struct packed {
        logic nt;     // nametable read in progress
        logic right;  // fetch targets the right horizontal page
    } fetch_kind_t;
endpackage

// File: rtl/snp_fetch_class.sv
// Module: combinational classifier of the current fetch.
// Assumes the read strobe is high for the whole fetch cycle.
module snp_fetch_class
    import snp_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int PAGE_BIT   = PAGE_BIT_DEF,
    parameter int REGION_MSB = REGION_MSB_DEF,
    parameter int REGION_LSB = REGION_LSB_DEF,
    parameter int REGION_VAL = REGION_VAL_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    output fetch_kind_t       kind
);
    localparam int RW = REGION_MSB - REGION_LSB + 1;
    localparam logic [RW-1:0] REGION_CODE = RW'(REGION_VAL);

    // Purpose: decode region and page of the fetch.
    always_comb begin
        kind.nt    = rd && (addr[REGION_MSB:REGION_LSB] == REGION_CODE);
        kind.right = kind.nt && addr[PAGE_BIT];
    end
endmodule

// File: rtl/snp_gap_detect.sv
// Module: finds the one-cycle idle slot that ends a scanline.
// Assumes the slot is exactly one cycle; longer idle runs are not gaps.
// gap_now is high in the first fetch cycle after such a slot.
module snp_gap_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    output logic gap_now
);
    logic rd_d1, rd_d2;

    // Purpose: keep two cycles of strobe history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_d1 <= 1'b0;
            rd_d2 <= 1'b0;
        end else begin
            rd_d1 <= rd;
            rd_d2 <= rd_d1;
        end
    end

    // Purpose: high, low, high pattern marks a line boundary.
    always_comb gap_now = rd && !rd_d1 && rd_d2;
endmodule

// File: rtl/snp_page_track.sv
// Module: per-line page-wrap tracker.
// Assumes gap_now is only high in a fetch cycle; the clear applies to that
// cycle's evaluation. ext_now is combinational for the current fetch.
module snp_page_track
    import snp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  fetch_kind_t kind,
    input  logic        gap_now,
    output logic        ext_now
);
    logic seen_q, wrap_q;
    logic seen_n, wrap_n;
    logic seen_base, wrap_base;

    // Purpose: apply the line clear, then fold in the current fetch.
    always_comb begin
        seen_base = gap_now ? 1'b0 : seen_q;
        wrap_base = gap_now ? 1'b0 : wrap_q;
        seen_n    = seen_base;
        wrap_n    = wrap_base;
        if (kind.nt) begin
            wrap_n = wrap_base || (seen_base && !kind.right);
            seen_n = seen_base || kind.right;
        end
        ext_now = kind.nt && wrap_n;
    end

    // Purpose: hold tracking state between cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            seen_q <= seen_n;
            wrap_q <= wrap_n;
        end
    end
endmodule

// File: rtl/nt_page_ext.sv
// Module: top of the nametable page extension snooper.
// Watches the fetch bus and registers one extra nametable address bit.
// Assumes one fetch per pixel clock and a single idle slot per scanline.
module nt_page_ext
    import snp_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int PAGE_BIT = PAGE_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_rd,
    output logic              ext_o
);
    fetch_kind_t kind;
    logic        gap_now;
    logic        ext_now;

    snp_fetch_class #(
        .ADDR_W   (ADDR_W),
        .PAGE_BIT (PAGE_BIT)
    ) u_class (
        .addr (fetch_addr),
        .rd   (fetch_rd),
        .kind (kind)
    );

    snp_gap_detect u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (fetch_rd),
        .gap_now (gap_now)
    );

    snp_page_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .gap_now (gap_now),
        .ext_now (ext_now)
    );

    // Purpose: register the output bit so it is stable over the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_o <= 1'b0;
        else        ext_o <= ext_now;
    end
endmodule

// File: rtl/snp_checker.sv
// Module: assertion checker for nt_page_ext, attached by bind.
// Decodes the bus on its own from the requirement encodings.
module snp_checker #(
    parameter int ADDR_W   = 14,
    parameter int PAGE_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_rd,
    input logic              ext_o
);
    logic nt_c, left_c, right_c, was_rst;

    // Purpose: independent nametable and page decode.
    always_comb begin
        nt_c    = fetch_rd && (fetch_addr[13:12] == 2'b10);
        left_c  = nt_c && !fetch_addr[PAGE_BIT];
        right_c = nt_c && fetch_addr[PAGE_BIT];
    end

    // Purpose: check the output after every reset edge.
    always_ff @(posedge clk) begin
        if (was_rst == 1'b1) begin
            p_reset_clear_r1: assert (!ext_o);
        end
        was_rst <= !rst_n;
    end

    p_nonnt_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !nt_c |=> !ext_o);

    p_gap_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rd ##1 !fetch_rd ##1 left_c |=> !ext_o);

    p_wrap_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        right_c ##1 left_c |=> ext_o);

    p_hold_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_o && nt_c && $past(fetch_rd)) |=> ext_o);
endmodule

bind nt_page_ext snp_checker #(
    .ADDR_W   (ADDR_W),
    .PAGE_BIT (PAGE_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_addr (fetch_addr),
    .fetch_rd   (fetch_rd),
    .ext_o      (ext_o)
);

// File: tb/tb_nt_page_ext.sv
`timescale 1ns/1ps
// Bench: vector table of fetch cycles, then directed reset cases.
module tb_nt_page_ext;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] fetch_addr;
    logic        fetch_rd;
    logic        ext_o;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    nt_page_ext dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_addr (fetch_addr),
        .fetch_rd   (fetch_rd),
        .ext_o      (ext_o)
    );

    always #2 clk = ~clk;  // 250 MHz

    // Entry: {req tag, rd, addr, expected ext_o one cycle later (R6)}
    localparam int NV = 24;
    localparam logic [19:0] VEC [NV] = '{
        {4'd7, 1'b1, 14'h2000, 1'b0},  // R7 left, nothing seen
        {4'd2, 1'b1, 14'h0010, 1'b0},  // R2 pattern fetch
        {4'd7, 1'b1, 14'h2001, 1'b0},  // R7
        {4'd4, 1'b1, 14'h2400, 1'b0},  // R4 right alone gives 0
        {4'd2, 1'b1, 14'h0020, 1'b0},  // R2
        {4'd4, 1'b1, 14'h2401, 1'b0},  // R4
        {4'd4, 1'b1, 14'h2002, 1'b1},  // R4 wrap to left
        {4'd2, 1'b1, 14'h1000, 1'b0},  // R2 gated off
        {4'd5, 1'b1, 14'h2402, 1'b1},  // R5 held on right
        {4'd2, 1'b1, 14'h3000, 1'b0},  // R2 outside range
        {4'd5, 1'b1, 14'h2003, 1'b1},  // R5
        {4'd2, 1'b0, 14'h0000, 1'b0},  // R2 gap slot
        {4'd3, 1'b1, 14'h2004, 1'b0},  // R3 cleared
        {4'd7, 1'b1, 14'h2005, 1'b0},  // R7 no-wrap line
        {4'd7, 1'b1, 14'h23C0, 1'b0},  // R7 bit10=0
        {4'd7, 1'b1, 14'h2800, 1'b0},  // R7 left, bit11 set
        {4'd4, 1'b1, 14'h2C00, 1'b0},  // R4 right
        {4'd2, 1'b0, 14'h0000, 1'b0},  // R2 idle
        {4'd2, 1'b0, 14'h0000, 1'b0},  // R2 idle (two cycles)
        {4'd8, 1'b1, 14'h2006, 1'b1},  // R8 state held, wrap
        {4'd5, 1'b1, 14'h2400, 1'b1},  // R5
        {4'd2, 1'b0, 14'h0000, 1'b0},  // R2 gap slot
        {4'd3, 1'b1, 14'h2401, 1'b0},  // R3 right after clear
        {4'd4, 1'b1, 14'h2007, 1'b1}   // R4 wrap again
    };

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: ext_o=%b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic rd, input logic [13:0] a);
        fetch_rd   = rd;
        fetch_addr = a;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; fetch_rd = 1'b0; fetch_addr = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", ext_o, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][15], VEC[i][14:1]);
            check($sformatf("R%0d vec %0d", VEC[i][19:16], i), ext_o, VEC[i][0]);
        end

        // R1: reset mid-line drops the bit and clears tracking
        drive(1'b1, 14'h2400);
        drive(1'b1, 14'h2000);
        check("R4 pre-reset wrap", ext_o, 1'b1);
        rst_n = 1'b0;
        drive(1'b1, 14'h2001);
        check("R1 output cleared", ext_o, 1'b0);
        rst_n = 1'b1;
        drive(1'b1, 14'h2002);
        check("R1 state cleared", ext_o, 1'b0);

        // R6: output holds between edges
        drive(1'b1, 14'h2403);
        drive(1'b1, 14'h2004);
        fetch_addr = 14'h0000;
        #1;
        check("R6 stable mid-cycle", ext_o, 1'b1);
        @(negedge clk);
        check("R2 after pattern", ext_o, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule